// File: doc/BRIEF.md
# Console I/O Register Block

This block sits on a processor's 16-bit address and data bus and answers five fixed addresses: the status and data registers of a keyboard input channel, the status and data registers of a display output channel, and a machine control register. Every other address is left to ordinary memory through a select output. A read returns the register value in the same cycle. A write takes effect at the next rising clock edge.

On the device side, a keyboard source delivers one character at a time with a single-cycle strobe. The display side receives each written character on a single-cycle strobe and reports with a done pulse when it can take the next character. Software runs a polling handshake on a ready flag held in the top bit of each status word. The keyboard flag rises when a character arrives and falls when software reads the character. The display flag falls when software writes a character and rises again on the device's done pulse.

The top bit of the machine control register drives a run-enable output that gates instruction processing. Clearing that bit halts the processor.

Top module: `console_io_regs`

## Requirements
- R1: After reset the display ready flag is 1, the keyboard ready flag is 0, `run_en` is 1 and `dsp_strobe` is 0.
- R2: `io_sel` is 1 exactly when `rd_en` or `wr_en` is high and `addr` is one of xF3FC (display status), xF3FF (display data), xF400 (keyboard status), xF401 (keyboard data) or xF402 (control). `mem_sel` is 1 when an access is made to any other address. When `io_sel` is 0, `rdata` is zero.
- R3: A cycle with `kbd_strobe` high stores `kbd_char` and sets the keyboard ready flag at the next edge. A read of xF401 returns the stored character in bits [7:0] and zero in bits [15:8].
- R4: A read of xF401 clears the keyboard ready flag at the next edge. If `kbd_strobe` is high in the same cycle, the strobe wins: the flag stays 1 and the new character is stored.
- R5: A read of either status address returns the ready flag in bit 15 and zero in bits [14:0].
- R6: A write to xF3FF clears the display ready flag. In the next cycle it drives `dsp_strobe` high for exactly one cycle, with `dsp_char` equal to `wdata[7:0]` of that write.
- R7: A `dsp_done` pulse sets the display ready flag at the next edge. If a write to xF3FF happens in the same cycle, the write wins and the flag is 0.
- R8: A write to xF402 loads `wdata[15]` into `run_en` at the next edge. A read of xF402 returns `run_en` in bit 15 and zero in bits [14:0].
- R9: Writes to the two status addresses and to xF401 change nothing that can be read back. A read of xF3FF returns zero.
- R10: An access to any address outside the five changes no register and raises no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 16 | Bus address |
| wdata | input | 16 | Bus write data |
| rd_en | input | 1 | Bus read request |
| wr_en | input | 1 | Bus write request |
| rdata | output | 16 | Read data, valid in the cycle of the read |
| io_sel | output | 1 | Access is claimed by this block |
| mem_sel | output | 1 | Access should go to memory |
| kbd_strobe | input | 1 | Keyboard character valid (one cycle) |
| kbd_char | input | 8 | Keyboard character |
| dsp_strobe | output | 1 | Display character valid (one cycle) |
| dsp_char | output | 8 | Display character |
| dsp_done | input | 1 | Display can take the next character |
| run_en | output | 1 | Instruction processing enable |

## Verification
The assertions run on every cycle. They check the flag transitions of both handshakes, the two collision priorities, the one-cycle display strobe and the byte it carries, the run-enable load, the zero bits of status and control reads, and that the two select outputs never rise together. Some behaviours show only in the bench's scenarios: a received character read back through the bus, the absence of any effect from writes to read-only or unmapped addresses, and the reset values seen through register reads.

// File: rtl/console_io_pkg.sv
package console_io_pkg;
  localparam int unsigned NUM_REGS = 5;

  typedef enum logic [2:0] {
    SLOT_DSP_STAT = 3'd0,
    SLOT_DSP_DATA = 3'd1,
    SLOT_KBD_STAT = 3'd2,
    SLOT_KBD_DATA = 3'd3,
    SLOT_CTRL     = 3'd4
  } reg_slot_e;

  localparam logic [15:0] DEF_DSP_STAT = 16'hF3FC;
  localparam logic [15:0] DEF_DSP_DATA = 16'hF3FF;
  localparam logic [15:0] DEF_KBD_STAT = 16'hF400;
  localparam logic [15:0] DEF_KBD_DATA = 16'hF401;
  localparam logic [15:0] DEF_CTRL     = 16'hF402;
endpackage

// File: rtl/cio_decode.sv
module cio_decode
  import console_io_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [NUM_REGS-1:0][ADDR_W-1:0] MAP = '0
) (
  input  logic [ADDR_W-1:0]   addr,
  input  logic                rd_en,
  input  logic                wr_en,
  output logic [NUM_REGS-1:0] rd_hit,
  output logic [NUM_REGS-1:0] wr_hit,
  output logic                io_sel,
  output logic                mem_sel
);
  logic [NUM_REGS-1:0] match;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cmp
    assign match[i]  = (addr == MAP[i]);
    assign rd_hit[i] = rd_en & match[i];
    assign wr_hit[i] = wr_en & match[i];
  end

  assign io_sel  = (rd_en | wr_en) & (|match);
  assign mem_sel = (rd_en | wr_en) & ~(|match);
endmodule

// File: rtl/cio_kbd.sv
module cio_kbd #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strobe,
  input  logic [CHAR_W-1:0] char_in,
  input  logic              data_rd,
  output logic              rdy,
  output logic [CHAR_W-1:0] char_q
);
  logic              rdy_d;
  logic [CHAR_W-1:0] char_d;
  logic              char_en;

  always_comb begin
    rdy_d   = rdy;
    char_en = strobe;
    char_d  = char_in;
    if (strobe)       rdy_d = 1'b1;
    else if (data_rd) rdy_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy    <= 1'b0;
      char_q <= '0;
    end else begin
      rdy <= rdy_d;
      if (char_en) char_q <= char_d;
    end
  end
endmodule

// File: rtl/cio_dsp.sv
module cio_dsp #(
  parameter int unsigned CHAR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              data_wr,
  input  logic [CHAR_W-1:0] wchar,
  input  logic              done,
  output logic              rdy,
  output logic              strobe,
  output logic [CHAR_W-1:0] char_q
);
  logic rdy_d;

  always_comb begin
    rdy_d = rdy;
    if (data_wr)   rdy_d = 1'b0;
    else if (done) rdy_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy    <= 1'b1;
      strobe <= 1'b0;
      char_q <= '0;
    end else begin
      rdy    <= rdy_d;
      strobe <= data_wr;
      if (data_wr) char_q <= wchar;
    end
  end
endmodule

// File: rtl/cio_ctl.sv
module cio_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr,
  input  logic run_bit,
  output logic run_q
);
  logic run_d;

  always_comb begin
    run_d = run_q;
    if (ctl_wr) run_d = run_bit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b1;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/console_io_regs.sv
module console_io_regs
  import console_io_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CHAR_W = 8,
  parameter logic [ADDR_W-1:0] DSP_STAT_ADDR = DEF_DSP_STAT,
  parameter logic [ADDR_W-1:0] DSP_DATA_ADDR = DEF_DSP_DATA,
  parameter logic [ADDR_W-1:0] KBD_STAT_ADDR = DEF_KBD_STAT,
  parameter logic [ADDR_W-1:0] KBD_DATA_ADDR = DEF_KBD_DATA,
  parameter logic [ADDR_W-1:0] CTRL_ADDR     = DEF_CTRL
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  output logic              io_sel,
  output logic              mem_sel,
  input  logic              kbd_strobe,
  input  logic [CHAR_W-1:0] kbd_char,
  output logic              dsp_strobe,
  output logic [CHAR_W-1:0] dsp_char,
  input  logic              dsp_done,
  output logic              run_en
);
  localparam int unsigned FLAG_BIT = DATA_W - 1;
  localparam logic [NUM_REGS-1:0][ADDR_W-1:0] MAP =
    {CTRL_ADDR, KBD_DATA_ADDR, KBD_STAT_ADDR, DSP_DATA_ADDR, DSP_STAT_ADDR};

  logic [NUM_REGS-1:0] rd_hit;
  logic [NUM_REGS-1:0] wr_hit;
  logic                kbd_rdy;
  logic [CHAR_W-1:0]   kbd_q;
  logic                dsp_rdy;

  cio_decode #(.ADDR_W(ADDR_W), .MAP(MAP)) u_dec (
    .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .io_sel(io_sel), .mem_sel(mem_sel)
  );

  cio_kbd #(.CHAR_W(CHAR_W)) u_kbd (
    .clk(clk), .rst_n(rst_n), .strobe(kbd_strobe), .char_in(kbd_char),
    .data_rd(rd_hit[SLOT_KBD_DATA]), .rdy(kbd_rdy), .char_q(kbd_q)
  );

  cio_dsp #(.CHAR_W(CHAR_W)) u_dsp (
    .clk(clk), .rst_n(rst_n), .data_wr(wr_hit[SLOT_DSP_DATA]),
    .wchar(wdata[CHAR_W-1:0]), .done(dsp_done), .rdy(dsp_rdy),
    .strobe(dsp_strobe), .char_q(dsp_char)
  );

  cio_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .ctl_wr(wr_hit[SLOT_CTRL]),
    .run_bit(wdata[FLAG_BIT]), .run_q(run_en)
  );

  always_comb begin
    rdata = '0;
    if (rd_hit[SLOT_DSP_STAT]) rdata[FLAG_BIT] = dsp_rdy;
    if (rd_hit[SLOT_KBD_STAT]) rdata[FLAG_BIT] = kbd_rdy;
    if (rd_hit[SLOT_KBD_DATA]) rdata[CHAR_W-1:0] = kbd_q;
    if (rd_hit[SLOT_CTRL])     rdata[FLAG_BIT] = run_en;
  end
endmodule

// File: rtl/console_io_chk.sv
module console_io_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] addr,
  input logic [15:0] wdata,
  input logic        rd_en,
  input logic        wr_en,
  input logic [15:0] rdata,
  input logic        io_sel,
  input logic        mem_sel,
  input logic        kbd_strobe,
  input logic        kbd_rdy,
  input logic        dsp_rdy,
  input logic        dsp_strobe,
  input logic [7:0]  dsp_char,
  input logic        dsp_done,
  input logic        run_en
);
  logic kd_rd, dd_wr, ct_wr, st_rd, ct_rd;
  assign kd_rd = rd_en && addr == 16'hF401;
  assign dd_wr = wr_en && addr == 16'hF3FF;
  assign ct_wr = wr_en && addr == 16'hF402;
  assign st_rd = rd_en && (addr == 16'hF3FC || addr == 16'hF400);
  assign ct_rd = rd_en && addr == 16'hF402;

  a_r2_sel_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(io_sel && mem_sel));
  a_r3_kbd_sets: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_strobe |=> kbd_rdy);
  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (kd_rd && !kbd_strobe) |=> !kbd_rdy);
  a_r5_status_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    st_rd |-> rdata[14:0] == 15'd0);
  a_r6_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    dd_wr |=> (dsp_strobe && dsp_char == $past(wdata[7:0]) && !dsp_rdy));
  a_r6_strobe_cause: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_strobe |-> $past(dd_wr));
  a_r7_done_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (dsp_done && !dd_wr) |=> dsp_rdy);
  a_r8_run_load: assert property (@(posedge clk) disable iff (!rst_n)
    ct_wr |=> run_en == $past(wdata[15]));
  a_r8_ctrl_read: assert property (@(posedge clk) disable iff (!rst_n)
    ct_rd |-> (rdata[15] == run_en && rdata[14:0] == 15'd0));
endmodule

bind console_io_regs console_io_chk u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
  .wr_en(wr_en), .rdata(rdata), .io_sel(io_sel), .mem_sel(mem_sel),
  .kbd_strobe(kbd_strobe), .kbd_rdy(kbd_rdy), .dsp_rdy(dsp_rdy),
  .dsp_strobe(dsp_strobe), .dsp_char(dsp_char), .dsp_done(dsp_done),
  .run_en(run_en)
);

// File: tb/sim_console_io_regs.sv
`timescale 1ns/1ps
module sim_console_io_regs;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] addr, wdata, rdata;
  logic        rd_en, wr_en, io_sel, mem_sel;
  logic        kbd_strobe, dsp_strobe, dsp_done, run_en;
  logic [7:0]  kbd_char, dsp_char;
  int          n_run = 0;
  int          n_fail = 0;

  always #4 clk = ~clk;

  console_io_regs u0 (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .rd_en(rd_en),
    .wr_en(wr_en), .rdata(rdata), .io_sel(io_sel), .mem_sel(mem_sel),
    .kbd_strobe(kbd_strobe), .kbd_char(kbd_char), .dsp_strobe(dsp_strobe),
    .dsp_char(dsp_char), .dsp_done(dsp_done), .run_en(run_en)
  );

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // read in one cycle: value sampled mid-cycle, side effect lands at next edge
  task automatic bus_read(input logic [15:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic kbd_send(input logic [7:0] c);
    @(negedge clk); kbd_strobe = 1'b1; kbd_char = c;
    @(negedge clk); kbd_strobe = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    chk("R1 run_en", {15'd0, run_en}, 16'd1);
    chk("R1 dsp_strobe", {15'd0, dsp_strobe}, 16'd0);
    bus_read(16'hF3FC, d); chk("R1 display ready", d, 16'h8000);
    bus_read(16'hF400, d); chk("R1 keyboard ready", d, 16'h0000);
    bus_read(16'hF402, d); chk("R1 control", d, 16'h8000);
  endtask

  task automatic t_kbd_receive();
    logic [15:0] d;
    kbd_send(8'h41);
    bus_read(16'hF400, d); chk("R3 kbd ready set", d, 16'h8000);
    bus_read(16'hF401, d); chk("R3 kbd data", d, 16'h0041);
    bus_read(16'hF400, d); chk("R4 kbd ready cleared", d, 16'h0000);
    bus_read(16'hF401, d); chk("R3 kbd data held", d, 16'h0041);
  endtask

  task automatic t_kbd_collision();
    logic [15:0] d;
    kbd_send(8'hC3);
    @(negedge clk); addr = 16'hF401; rd_en = 1'b1; kbd_strobe = 1'b1; kbd_char = 8'h5A;
    #1 chk("R4 read sees old char", rdata, 16'h00C3);
    @(negedge clk); rd_en = 1'b0; kbd_strobe = 1'b0;
    bus_read(16'hF400, d); chk("R4 strobe wins over read", d, 16'h8000);
    bus_read(16'hF401, d); chk("R4 new char stored", d, 16'h005A);
  endtask

  task automatic t_dsp();
    logic [15:0] d;
    @(negedge clk); addr = 16'hF3FF; wdata = 16'h1234; wr_en = 1'b1;
    #1 chk("R6 no strobe during write", {15'd0, dsp_strobe}, 16'd0);
    @(negedge clk); wr_en = 1'b0;
    chk("R6 strobe", {15'd0, dsp_strobe}, 16'd1);
    chk("R6 char", {8'd0, dsp_char}, 16'h0034);
    @(negedge clk);
    chk("R6 strobe one cycle", {15'd0, dsp_strobe}, 16'd0);
    bus_read(16'hF3FC, d); chk("R6 display busy", d, 16'h0000);
    @(negedge clk); dsp_done = 1'b1;
    @(negedge clk); dsp_done = 1'b0;
    bus_read(16'hF3FC, d); chk("R7 display ready after done", d, 16'h8000);
  endtask

  task automatic t_dsp_collision();
    logic [15:0] d;
    @(negedge clk); addr = 16'hF3FF; wdata = 16'h0077; wr_en = 1'b1; dsp_done = 1'b1;
    @(negedge clk); wr_en = 1'b0; dsp_done = 1'b0;
    chk("R7 collision strobe", {15'd0, dsp_strobe}, 16'd1);
    bus_read(16'hF3FC, d); chk("R7 write wins over done", d, 16'h0000);
    @(negedge clk); dsp_done = 1'b1;
    @(negedge clk); dsp_done = 1'b0;
  endtask

  task automatic t_ctrl();
    logic [15:0] d;
    bus_write(16'hF402, 16'h7FFF);
    chk("R8 run cleared", {15'd0, run_en}, 16'd0);
    bus_read(16'hF402, d); chk("R8 control read 0", d, 16'h0000);
    bus_write(16'hF402, 16'h8000);
    chk("R8 run set", {15'd0, run_en}, 16'd1);
    bus_read(16'hF402, d); chk("R8 control read 1", d, 16'h8000);
  endtask

  task automatic t_readonly();
    logic [15:0] d;
    bus_write(16'hF3FC, 16'h0000);
    bus_write(16'hF400, 16'hFFFF);
    bus_write(16'hF401, 16'hFF11);
    chk("R9 no strobe", {15'd0, dsp_strobe}, 16'd0);
    bus_read(16'hF3FC, d); chk("R9 display status kept", d, 16'h8000);
    bus_read(16'hF400, d); chk("R9 kbd status kept", d, 16'h0000);
    bus_read(16'hF401, d); chk("R9 kbd data kept", d, 16'h005A);
    bus_read(16'hF3FF, d); chk("R9 display data reads 0", d, 16'h0000);
  endtask

  task automatic t_unmapped();
    logic [15:0] d;
    @(negedge clk);
    chk("R2 idle io_sel", {15'd0, io_sel}, 16'd0);
    chk("R2 idle mem_sel", {15'd0, mem_sel}, 16'd0);
    addr = 16'hF3FD; rd_en = 1'b1;
    #1 chk("R2 unmapped io_sel", {15'd0, io_sel}, 16'd0);
    chk("R2 unmapped mem_sel", {15'd0, mem_sel}, 16'd1);
    chk("R2 unmapped rdata", rdata, 16'h0000);
    @(negedge clk); addr = 16'hF400;
    #1 chk("R2 mapped io_sel", {15'd0, io_sel}, 16'd1);
    chk("R2 mapped mem_sel", {15'd0, mem_sel}, 16'd0);
    @(negedge clk); rd_en = 1'b0;
    bus_write(16'hF3FE, 16'h00AA);
    chk("R10 no strobe", {15'd0, dsp_strobe}, 16'd0);
    bus_write(16'hF403, 16'h0000);
    chk("R10 run kept", {15'd0, run_en}, 16'd1);
    bus_read(16'h3000, d); chk("R10 memory read rdata", d, 16'h0000);
    bus_read(16'hF3FC, d); chk("R10 display status kept", d, 16'h8000);
  endtask

  initial begin
    #1_600_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; addr = '0; wdata = '0; rd_en = 1'b0; wr_en = 1'b0;
    kbd_strobe = 1'b0; kbd_char = '0; dsp_done = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_kbd_receive();
    t_kbd_collision();
    t_dsp();
    t_dsp_collision();
    t_ctrl();
    t_readonly();
    t_unmapped();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule